// File: doc/BRIEF.md
# Ethernet MAC Control Register Block with Graceful Receive Drain

This block holds the software-visible configuration of an Ethernet MAC and turns it into level signals for the MAC datapath. Software reaches it through a plain 32-bit register port: a write strobe with address and data, and a read strobe whose data comes back one cycle later with a valid flag. The block keeps a command word of enable and option bits, a maximum frame length, and a 48-bit station address split over two words. It also keeps a sticky event word that records when the datapath reports its receive and transmit sides drained.

Two behaviours set it apart from a plain register file. A software-reset bit starts a fixed-length reset pulse toward the datapath. The bit reads as set for as long as the pulse lasts and clears itself afterwards, and every other register is held at its default value during the pulse. A receive-stop request bit supports an orderly shutdown. Software raises the request, waits for the receive-drained event, drops the receive enable, then waits for the transmit-drained event before dropping the transmit enable.

The reset sequencer is a two-state machine. In `SR_IDLE` the pulse output is low. A write to the command word with the reset bit set takes the transition *start* into `SR_PULSE`, where a counter runs. When the counter reaches its last value, the transition *done* returns the machine to `SR_IDLE`. A reset-bit write that arrives while the machine is in `SR_PULSE` is ignored.

Top module: `mac_csr`

## Requirements
- R1: After the reset input is released, the command word reads 0, the maximum frame length reads 1536, both address words read 0, the event word reads 0, and all enable, option and pulse outputs are low.
- R2: The command word is at offset 0x008. Its writable bits, which also drive the outputs, are: bit 0 tx_enable, bit 1 rx_enable, bit 4 promisc_en, bit 6 crc_append, bit 11 pad_en, bit 17 len_check_off, bit 29 rx_stop_req. All other bits read 0, except bit 12 (see R3).
- R3: Writing 1 to bit 12 of the command word raises sw_reset for exactly 8 consecutive cycles, starting in the cycle after the write. Bit 12 reads 1 during the pulse and 0 after it.
- R4: On the reset-bit write and throughout the pulse, every other register returns to its R1 value, and any register write arriving during the pulse has no effect.
- R5: A write to offset 0x014 with a value from 64 to 32736 inclusive sets the maximum frame length. The value reads back in bits 15:0 and appears on max_frame_len.
- R6: A write to offset 0x014 with any 32-bit value outside 64..32736 is ignored, and the previous length stays.
- R7: Offset 0x00C holds station-address bytes 0 to 3, with byte 0 in bits 7:0. Offset 0x010 holds bytes 4 and 5 in bits 15:0, and its bits 31:16 read 0. station_addr carries byte 0 in bits 7:0 up to byte 5 in bits 47:40.
- R8: Event bit 6 (offset 0x040) is set at the end of the first cycle in which rx_stop_req and rx_empty are both high. It stays set until it is cleared.
- R9: Event bit 5 is set at the end of a cycle in which rx_stop_req is high, rx_enable is low and tx_empty is high. It stays set until it is cleared.
- R10: Any write to offset 0x040 clears both event bits. If a bit's set condition holds in the same cycle, that bit stays set.
- R11: Reads of any offset other than 0x008, 0x00C, 0x010, 0x014 and 0x040 return 0. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after bus_rd |
| rx_empty | input | 1 | Datapath receive side drained |
| tx_empty | input | 1 | Datapath transmit side drained |
| rx_enable | output | 1 | Receive enable |
| tx_enable | output | 1 | Transmit enable |
| rx_stop_req | output | 1 | Receive-stop request |
| sw_reset | output | 1 | Datapath reset pulse |
| promisc_en | output | 1 | Accept all destination addresses |
| crc_append | output | 1 | Append FCS on transmit |
| pad_en | output | 1 | Pad short transmit frames |
| len_check_off | output | 1 | Disable receive length check |
| max_frame_len | output | 16 | Maximum frame length in bytes |
| station_addr | output | 48 | Station MAC address |

## Verification
A register write lands at the clock edge that ends its cycle. The outputs driven by that register change right after that edge, so the bench samples them at the next falling edge. A read returns its data one cycle after the read strobe and reflects state from before that edge. The monitor therefore pops its expected word from the scoreboard queue on the falling edge where bus_rvalid is high. An event bit set by a drain condition in cycle k is visible to a read issued in cycle k+1 or later, and the bench changes the drain inputs a full cycle before it reads. The length of the reset pulse is counted on falling edges by an independent process, and that count must come to exactly 8.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CMD     = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_ADDR_LO = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_ADDR_HI = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MAXFRM  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_EVENT   = 12'h040;

    localparam int B_TXEN    = 0;
    localparam int B_RXEN    = 1;
    localparam int B_PROMISC = 4;
    localparam int B_CRC     = 6;
    localparam int B_PAD     = 11;
    localparam int B_SWR     = 12;
    localparam int B_NOLEN   = 17;
    localparam int B_RXSTOP  = 29;

    localparam int EV_TXDONE = 5;
    localparam int EV_RXDONE = 6;

    localparam logic [DATA_W-1:0] CMD_WMASK =
        (32'd1 << B_TXEN) | (32'd1 << B_RXEN) | (32'd1 << B_PROMISC) |
        (32'd1 << B_CRC) | (32'd1 << B_PAD) | (32'd1 << B_NOLEN) |
        (32'd1 << B_RXSTOP);

    typedef enum logic [0:0] {
        SR_IDLE  = 1'b0,
        SR_PULSE = 1'b1
    } srst_state_e;
endpackage

// File: rtl/mac_csr_swrst.sv
module mac_csr_swrst
    import mac_csr_pkg::*;
#(
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);

    srst_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SR_IDLE: begin
                if (start) begin            // transition: start
                    state_d = SR_PULSE;
                    cnt_d   = '0;
                end
            end
            SR_PULSE: begin
                if (cnt_q == LAST) begin    // transition: done
                    state_d = SR_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy = (state_q == SR_PULSE);
    end

    AST_PULSE_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != LAST) |=> busy); // R3
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == LAST) |=> !busy); // R3
endmodule

// File: rtl/mac_csr_events.sv
module mac_csr_events (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic clr,
    input  logic stop_req,
    input  logic rx_en,
    input  logic rx_empty,
    input  logic tx_empty,
    output logic ev_rx,
    output logic ev_tx
);
    logic set_rx, set_tx;

    always_comb begin
        set_rx = stop_req && rx_empty;
        set_tx = stop_req && !rx_en && tx_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_rx <= 1'b0;
            ev_tx <= 1'b0;
        end else if (hold) begin
            ev_rx <= 1'b0;
            ev_tx <= 1'b0;
        end else begin
            ev_rx <= set_rx || (ev_rx && !clr);
            ev_tx <= set_tx || (ev_tx && !clr);
        end
    end

    AST_TXFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx && !hold && !clr) |=> ev_tx); // R9
endmodule

// File: rtl/mac_csr.sv
module mac_csr
    import mac_csr_pkg::*;
#(
    parameter int MIN_FRAME    = 64,
    parameter int MAX_FRAME    = 32736,
    parameter int DEF_FRAME    = 1536,
    parameter int MF_W         = 16,
    parameter int RST_CYCLES   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_rd,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_rvalid,
    input  logic                 rx_empty,
    input  logic                 tx_empty,
    output logic                 rx_enable,
    output logic                 tx_enable,
    output logic                 rx_stop_req,
    output logic                 sw_reset,
    output logic                 promisc_en,
    output logic                 crc_append,
    output logic                 pad_en,
    output logic                 len_check_off,
    output logic [MF_W-1:0]      max_frame_len,
    output logic [47:0]          station_addr
);
    localparam logic [DATA_W-1:0] LO_LIM = DATA_W'(MIN_FRAME);
    localparam logic [DATA_W-1:0] HI_LIM = DATA_W'(MAX_FRAME);
    localparam logic [MF_W-1:0]   MF_DEF = MF_W'(DEF_FRAME);

    logic [DATA_W-1:0] cmd_q;
    logic [31:0]       addr_lo_q;
    logic [15:0]       addr_hi_q;
    logic [MF_W-1:0]   mf_q;
    logic              busy, start, hold;
    logic              wr_cmd, wr_lo, wr_hi, wr_mf, wr_ev, mf_ok;
    logic              ev_rx, ev_tx;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        wr_cmd = bus_wr && (bus_addr == OFS_CMD)     && !busy;
        wr_lo  = bus_wr && (bus_addr == OFS_ADDR_LO) && !busy;
        wr_hi  = bus_wr && (bus_addr == OFS_ADDR_HI) && !busy;
        wr_mf  = bus_wr && (bus_addr == OFS_MAXFRM)  && !busy;
        wr_ev  = bus_wr && (bus_addr == OFS_EVENT)   && !busy;
        mf_ok  = (bus_wdata >= LO_LIM) && (bus_wdata <= HI_LIM);
        start  = wr_cmd && bus_wdata[B_SWR];
        hold   = start || busy;
    end

    mac_csr_swrst #(.PULSE_CYCLES(RST_CYCLES)) u_swrst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy)
    );

    mac_csr_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .clr      (wr_ev),
        .stop_req (cmd_q[B_RXSTOP]),
        .rx_en    (cmd_q[B_RXEN]),
        .rx_empty (rx_empty),
        .tx_empty (tx_empty),
        .ev_rx    (ev_rx),
        .ev_tx    (ev_tx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            mf_q      <= MF_DEF;
        end else if (hold) begin
            cmd_q     <= '0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            mf_q      <= MF_DEF;
        end else begin
            if (wr_cmd)         cmd_q     <= bus_wdata & CMD_WMASK;
            if (wr_lo)          addr_lo_q <= bus_wdata;
            if (wr_hi)          addr_hi_q <= bus_wdata[15:0];
            if (wr_mf && mf_ok) mf_q      <= bus_wdata[MF_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_CMD:     rd_mux = cmd_q | (DATA_W'(busy) << B_SWR);
            OFS_ADDR_LO: rd_mux = addr_lo_q;
            OFS_ADDR_HI: rd_mux = {16'h0, addr_hi_q};
            OFS_MAXFRM:  rd_mux = DATA_W'(mf_q);
            OFS_EVENT:   rd_mux = (DATA_W'(ev_rx) << EV_RXDONE) |
                                  (DATA_W'(ev_tx) << EV_TXDONE);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_mux : '0;
        end
    end

    always_comb begin
        tx_enable     = cmd_q[B_TXEN];
        rx_enable     = cmd_q[B_RXEN];
        promisc_en    = cmd_q[B_PROMISC];
        crc_append    = cmd_q[B_CRC];
        pad_en        = cmd_q[B_PAD];
        len_check_off = cmd_q[B_NOLEN];
        rx_stop_req   = cmd_q[B_RXSTOP];
        sw_reset      = busy;
        max_frame_len = mf_q;
        station_addr  = {addr_hi_q, addr_lo_q};
    end

    AST_SWR_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_reset) |-> $past(start)); // R3
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |-> (!rx_enable && !tx_enable && !rx_stop_req && max_frame_len == MF_DEF)); // R4
    AST_FRAME_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (max_frame_len >= MF_W'(MIN_FRAME) && max_frame_len <= MF_W'(MAX_FRAME))); // R6
    AST_RXFLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stop_req && rx_empty && !hold) |=> ev_rx); // R8
    AST_RXFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx && !hold && !wr_ev) |=> ev_rx); // R8
    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R11
endmodule

// File: tb/mac_csr_bench.sv
module mac_csr_bench;
    typedef struct {
        logic [11:0] addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        rx_empty = 1'b0;
    logic        tx_empty = 1'b0;
    logic        rx_enable, tx_enable, rx_stop_req, sw_reset;
    logic        promisc_en, crc_append, pad_en, len_check_off;
    logic [15:0] max_frame_len;
    logic [47:0] station_addr;

    int       errors = 0;
    int       checks = 0;
    int       hi_cnt = 0;
    bit       done = 1'b0;
    rd_item_t sb_q[$];

    always #5 clk = ~clk;

    mac_csr u_mac_csr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .rx_empty(rx_empty), .tx_empty(tx_empty),
        .rx_enable(rx_enable), .tx_enable(tx_enable), .rx_stop_req(rx_stop_req),
        .sw_reset(sw_reset), .promisc_en(promisc_en), .crc_append(crc_append),
        .pad_en(pad_en), .len_check_off(len_check_off),
        .max_frame_len(max_frame_len), .station_addr(station_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: results are due one cycle after the read strobe
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R11 unexpected read data", {32'h0, bus_rdata}, 64'h0);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk(bus_rdata == it.exp, it.tag, {32'h0, bus_rdata}, {32'h0, it.exp});
            end
        end
    end

    always @(negedge clk) if (rst_n && sw_reset) hi_cnt++;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({rx_enable, tx_enable, rx_stop_req, sw_reset, promisc_en, crc_append,
             pad_en, len_check_off} == 8'h0, "R1 outputs low", {56'h0, rx_enable, tx_enable,
             rx_stop_req, sw_reset, promisc_en, crc_append, pad_en, len_check_off}, 64'h0);
        rd(12'h008, 32'h0, "R1 cmd default");
        rd(12'h014, 32'd1536, "R1 maxfrm default");
        rd(12'h00C, 32'h0, "R1 addr lo default");
        rd(12'h010, 32'h0, "R1 addr hi default");
        rd(12'h040, 32'h0, "R1 event default");

        // R2 command bits
        wr(12'h008, 32'hFFFF_EFFF);
        rd(12'h008, 32'h2002_0853, "R2 cmd readback mask");
        chk({tx_enable, rx_enable, promisc_en, crc_append, pad_en, len_check_off, rx_stop_req}
            == 7'h7F, "R2 outputs follow bits", {57'h0, tx_enable, rx_enable, promisc_en,
            crc_append, pad_en, len_check_off, rx_stop_req}, 64'h7F);
        wr(12'h008, 32'h0000_0012);
        chk({tx_enable, rx_enable, promisc_en} == 3'b011, "R2 partial pattern",
            {61'h0, tx_enable, rx_enable, promisc_en}, 64'h3);

        // R8 receive drained event
        wr(12'h008, 32'h2000_0003);
        @(negedge clk); rx_empty = 1'b1;
        @(negedge clk); rx_empty = 1'b0;
        rd(12'h040, 32'h40, "R8 rx flag set");
        rd(12'h040, 32'h40, "R8 rx flag sticky");
        // R9 transmit drained after rx enable dropped
        @(negedge clk); tx_empty = 1'b1;
        @(negedge clk); tx_empty = 1'b0;
        rd(12'h040, 32'h40, "R9 tx flag needs rx_enable low");
        wr(12'h008, 32'h2000_0001);
        @(negedge clk); tx_empty = 1'b1;
        @(negedge clk);
        rd(12'h040, 32'h60, "R9 tx flag set");
        // R10 clear with set condition still true
        wr(12'h040, 32'h0);
        rd(12'h040, 32'h20, "R10 set wins over clear");
        @(negedge clk); tx_empty = 1'b0;
        wr(12'h040, 32'h0);
        rd(12'h040, 32'h0, "R10 clear both");

        // R5 / R6 max frame length
        wr(12'h014, 32'd9000);
        rd(12'h014, 32'd9000, "R5 maxfrm 9000");
        chk(max_frame_len == 16'd9000, "R5 port", {48'h0, max_frame_len}, 64'd9000);
        wr(12'h014, 32'd64);
        rd(12'h014, 32'd64, "R5 lower bound");
        wr(12'h014, 32'd32736);
        rd(12'h014, 32'd32736, "R5 upper bound");
        wr(12'h014, 32'd63);
        rd(12'h014, 32'd32736, "R6 below range ignored");
        wr(12'h014, 32'd32737);
        rd(12'h014, 32'd32736, "R6 above range ignored");
        wr(12'h014, 32'h0001_0040);
        rd(12'h014, 32'd32736, "R6 high bits ignored");

        // R7 station address
        wr(12'h00C, 32'h4433_2211);
        wr(12'h010, 32'hDEAD_6655);
        rd(12'h00C, 32'h4433_2211, "R7 addr lo");
        rd(12'h010, 32'h0000_6655, "R7 addr hi");
        chk(station_addr == 48'h6655_4433_2211, "R7 port", {16'h0, station_addr},
            64'h6655_4433_2211);

        // R11 undefined offsets
        wr(12'h018, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h018, 32'h0, "R11 undefined read 018");
        rd(12'h004, 32'h0, "R11 undefined read 004");
        rd(12'h008, 32'h2000_0001, "R11 cmd untouched");
        rd(12'h014, 32'd32736, "R11 maxfrm untouched");

        // R3 / R4 soft reset
        hi_cnt = 0;
        wr(12'h008, 32'h0000_1003);
        rd(12'h008, 32'h0000_1000, "R3 reset bit reads 1");
        wr(12'h014, 32'd100);
        repeat (10) @(negedge clk);
        chk(hi_cnt == 8, "R3 pulse length", 64'(hi_cnt), 64'd8);
        rd(12'h008, 32'h0, "R3 reset bit self-clears");
        rd(12'h014, 32'd1536, "R4 maxfrm default, write ignored");
        rd(12'h00C, 32'h0, "R4 addr lo default");
        rd(12'h010, 32'h0, "R4 addr hi default");
        chk({rx_enable, tx_enable, rx_stop_req, sw_reset} == 4'h0, "R4 outputs low",
            {60'h0, rx_enable, tx_enable, rx_stop_req, sw_reset}, 64'h0);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R11 all reads returned", 64'(sb_q.size()), 64'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule